// File: doc/BRIEF.md
# PWM Time-Base Counter with One-Shot Global Load Strobe

This block is the time base of a PWM channel. An up-counter runs from zero to a programmed period and then returns to zero. When phase loading is enabled, an external sync pulse can overwrite the counter with a programmed phase value. This lets an outside source restart the cycle before the period is reached. The phase value may be zero, or it may equal the period so that the next event is a period event.

The block raises a flag whenever the counter sits at zero and another whenever it sits at the period. These flags fire for values reached by a sync load just as they do for values reached by counting. A software write arms a one-shot latch. The latch then fires a single one-cycle global load strobe after the next counter event that matches the selected load mode: zero, period, or either. A downstream compare or dead-band stage uses this strobe to move shadow values into active registers. The latch clears itself after firing. Another write is needed for each further strobe.

Top module: `pwm_timebase_gld`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `cntOut` = 0, both event flags low, `gldPulse` low and the latch disarmed. The zero value left by reset is not an event: no flag is raised and no strobe fires until the counter has advanced at least once.
- R2: With no phase load and `cntOut` below `periodVal`, the counter increases by one on each clock.
- R3: With no phase load and `cntOut` at or above `periodVal`, the next value is 0.
- R4: When `phaseEn` and `syncIn` are both high at an edge, the next `cntOut` is `phaseVal`. This takes priority over counting and wrapping.
- R5: When `phaseEn` is low, `syncIn` has no effect on the counter.
- R6: Outside the first cycle after reset, `zeroFlag` is high exactly when `cntOut` = 0, and `periodFlag` is high exactly when `cntOut` = `periodVal`. This holds however the value was reached, including a sync load.
- R7: `loadMode` selects the event that fires the strobe. The encoding is 0 = zero event, 1 = period event, 2 or 3 = either event.
- R8: An `armWrite` pulse arms the latch. `gldPulse` goes high in the cycle after the first selected event seen at or after arming. The latch then clears, and later events produce no strobe until the next `armWrite`.
- R9: If `armWrite` is high in the same cycle as a selected event, the strobe fires on that event.
- R10: `gldPulse` is one cycle wide. It is never high in two consecutive cycles unless `armWrite` was high during the cycle of the first of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| periodVal | input | CNT_W | Period value; the counter wraps after reaching it |
| phaseVal | input | CNT_W | Value loaded by a sync pulse |
| phaseEn | input | 1 | Enables sync-driven phase loading |
| syncIn | input | 1 | External sync pulse |
| loadMode | input | 2 | Event select for the global load strobe |
| armWrite | input | 1 | Software arming write for the one-shot latch |
| cntOut | output | CNT_W | Current counter value |
| zeroFlag | output | 1 | Counter is at zero |
| periodFlag | output | 1 | Counter is at the period |
| gldPulse | output | 1 | One-cycle global shadow-to-active load strobe |

## Verification
The assertions assume that `periodVal` changes only while the counter is not compared against it in the same step. The stimulus meets this by holding `periodVal` and `phaseVal` constant between resets. The bench sweeps every load mode, periods from 0 to 6, and phase values of zero, the period itself and a middle value. Within each configuration, sync, phase-enable and arming pulses come from a pseudo-random sequence. As a result, arming often coincides with an event and syncs often land on or beside the period. The flag checks compare against the counter only after the first cycle following reset, which is the only window in which the zero reset value is deliberately not an event.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  typedef struct packed {
    logic clear;
    logic loadPhase;
  } tbStrobe_t;

  typedef enum logic [1:0] {
    LOAD_ON_ZERO   = 2'd0,
    LOAD_ON_PERIOD = 2'd1,
    LOAD_ON_EITHER = 2'd2,
    LOAD_ON_ANY    = 2'd3
  } loadSel_e;

endpackage

// File: rtl/pwm_tb_datapath.sv
module pwm_tb_datapath
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  tbStrobe_t        strobe,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [CNT_W-1:0] phaseVal,
  output logic [CNT_W-1:0] cntOut,
  output logic             zeroFlag,
  output logic             periodFlag
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntReg;
  logic             liveReg;

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      cntReg  <= '0;
      liveReg <= 1'b0;
    end else begin
      liveReg <= 1'b1;
      if (strobe.loadPhase)
        cntReg <= phaseVal;
      else if (cntReg >= periodVal)
        cntReg <= '0;
      else
        cntReg <= cntReg + CNT_ONE;
    end
  end

  assign cntOut     = cntReg;
  assign zeroFlag   = liveReg && (cntReg == '0);
  assign periodFlag = liveReg && (cntReg == periodVal);

endmodule

// File: rtl/pwm_tb_control.sv
module pwm_tb_control
  import pwm_tb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      syncIn,
  input  logic      phaseEn,
  input  logic      armWrite,
  input  logic [1:0] loadMode,
  input  logic      zeroFlag,
  input  logic      periodFlag,
  output tbStrobe_t strobe,
  output logic      gldPulse
);

  logic armed;
  logic eventHit;
  logic fireNow;
  loadSel_e modeSel;

  assign modeSel = loadSel_e'(loadMode);

  always_comb begin
    strobe.clear     = rst;
    strobe.loadPhase = phaseEn && syncIn;
  end

  always_comb begin
    unique case (modeSel)
      LOAD_ON_ZERO:   eventHit = zeroFlag;
      LOAD_ON_PERIOD: eventHit = periodFlag;
      default:        eventHit = zeroFlag || periodFlag;
    endcase
  end

  assign fireNow = eventHit && (armed || armWrite);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      gldPulse <= 1'b0;
    end else begin
      gldPulse <= fireNow;
      if (fireNow)
        armed <= 1'b0;
      else if (armWrite)
        armed <= 1'b1;
    end
  end

endmodule

// File: rtl/pwm_timebase_gld.sv
module pwm_timebase_gld
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [CNT_W-1:0] phaseVal,
  input  logic             phaseEn,
  input  logic             syncIn,
  input  logic [1:0]       loadMode,
  input  logic             armWrite,
  output logic [CNT_W-1:0] cntOut,
  output logic             zeroFlag,
  output logic             periodFlag,
  output logic             gldPulse
);

  tbStrobe_t strobe;

  pwm_tb_control u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .syncIn     (syncIn),
    .phaseEn    (phaseEn),
    .armWrite   (armWrite),
    .loadMode   (loadMode),
    .zeroFlag   (zeroFlag),
    .periodFlag (periodFlag),
    .strobe     (strobe),
    .gldPulse   (gldPulse)
  );

  pwm_tb_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .periodVal  (periodVal),
    .phaseVal   (phaseVal),
    .cntOut     (cntOut),
    .zeroFlag   (zeroFlag),
    .periodFlag (periodFlag)
  );

endmodule

// File: rtl/pwm_timebase_gld_chk.sv
module pwm_timebase_gld_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] periodVal,
  input logic [CNT_W-1:0] phaseVal,
  input logic             phaseEn,
  input logic             syncIn,
  input logic [1:0]       loadMode,
  input logic             armWrite,
  input logic [CNT_W-1:0] cntOut,
  input logic             zeroFlag,
  input logic             periodFlag,
  input logic             gldPulse
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic seenRun;
  logic selHit;

  always_ff @(posedge clk) begin
    if (rst) seenRun <= 1'b0;
    else     seenRun <= 1'b1;
  end

  assign selHit = (loadMode == 2'd0) ? zeroFlag :
                  (loadMode == 2'd1) ? periodFlag : (zeroFlag || periodFlag);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cntOut == '0 && !zeroFlag && !periodFlag && !gldPulse));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!(phaseEn && syncIn) && cntOut < periodVal && $stable(periodVal))
      |=> cntOut == $past(cntOut) + ONE);

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (!(phaseEn && syncIn) && cntOut >= periodVal) |=> cntOut == '0);

  assert_phase_load_R4: assert property (@(posedge clk) disable iff (rst)
    (phaseEn && syncIn) |=> cntOut == $past(phaseVal));

  assert_flags_track_R6: assert property (@(posedge clk) disable iff (rst)
    seenRun |-> (zeroFlag == (cntOut == '0)) && (periodFlag == (cntOut == periodVal)));

  assert_pulse_needs_event_R8: assert property (@(posedge clk) disable iff (rst)
    !selHit |=> !gldPulse);

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (rst)
    (gldPulse && !armWrite) |=> !gldPulse);

endmodule

bind pwm_timebase_gld pwm_timebase_gld_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .periodVal(periodVal), .phaseVal(phaseVal),
  .phaseEn(phaseEn), .syncIn(syncIn), .loadMode(loadMode), .armWrite(armWrite),
  .cntOut(cntOut), .zeroFlag(zeroFlag), .periodFlag(periodFlag), .gldPulse(gldPulse)
);

// File: tb/pwm_timebase_gld_tb.sv
module pwm_timebase_gld_tb;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] periodVal = 8'd4;
  logic [W-1:0] phaseVal = 8'd0;
  logic phaseEn = 1'b0;
  logic syncIn = 1'b0;
  logic [1:0] loadMode = 2'd0;
  logic armWrite = 1'b0;
  logic [W-1:0] cntOut;
  logic zeroFlag, periodFlag, gldPulse;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // reference state
  int  mCnt = 0;
  bit  mLive = 0;
  bit  mArmed = 0;
  bit  mPulse = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  pwm_timebase_gld #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .periodVal(periodVal), .phaseVal(phaseVal),
    .phaseEn(phaseEn), .syncIn(syncIn), .loadMode(loadMode), .armWrite(armWrite),
    .cntOut(cntOut), .zeroFlag(zeroFlag), .periodFlag(periodFlag), .gldPulse(gldPulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit hit;
    int per;
    @(posedge clk);
    per = int'(periodVal);
    if (rst) begin
      mCnt = 0; mLive = 0; mArmed = 0; mPulse = 0;
    end else begin
      case (loadMode)
        2'd0:    hit = mLive && mCnt == 0;
        2'd1:    hit = mLive && mCnt == per;
        default: hit = mLive && (mCnt == 0 || mCnt == per);
      endcase
      mPulse = hit && (mArmed || armWrite);
      if (mPulse) mArmed = 0;
      else if (armWrite) mArmed = 1;
      if (phaseEn && syncIn) mCnt = int'(phaseVal);
      else if (mCnt >= per) mCnt = 0;
      else mCnt = mCnt + 1;
      mLive = 1;
    end
    @(negedge clk);
    check(int'(cntOut) == mCnt, "R2/R3/R4 counter", int'(cntOut), mCnt);
    check(zeroFlag == (mLive && mCnt == 0), "R6 zero flag", int'(zeroFlag), int'(mLive && mCnt == 0));
    check(periodFlag == (mLive && mCnt == per), "R6 period flag", int'(periodFlag),
          int'(mLive && mCnt == per));
    check(gldPulse == mPulse, "R8 load strobe", int'(gldPulse), int'(mPulse));
  endtask

  task automatic doReset();
    rst = 1'b1; syncIn = 1'b0; armWrite = 1'b0; phaseEn = 1'b0;
    step();
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    doReset();
    check(cntOut == 0 && !zeroFlag && !periodFlag && !gldPulse, "R1 reset outputs",
          int'(cntOut), 0);
    // R1/R8: without arming no strobe ever appears
    begin
      bit anyPulse = 0;
      for (int i = 0; i < 12; i++) begin step(); anyPulse |= gldPulse; end
      check(!anyPulse, "R1 latch disarmed after reset", int'(anyPulse), 0);
    end

    // R5: sync ignored while phase loading disabled
    doReset();
    phaseVal = 8'd0;
    step(); step(); // cnt = 2
    syncIn = 1'b1; phaseEn = 1'b0;
    step();
    syncIn = 1'b0;
    check(cntOut == 3, "R5 sync ignored", int'(cntOut), 3);

    // R4/R6: sync loads period value, raising the period flag
    phaseVal = periodVal; phaseEn = 1'b1; syncIn = 1'b1;
    step();
    syncIn = 1'b0;
    check(cntOut == periodVal && periodFlag && !zeroFlag, "R4 phase load of period",
          int'(cntOut), int'(periodVal));

    // R9/R10: arm in the same cycle as a zero event
    doReset(); loadMode = 2'd0; phaseEn = 1'b0;
    for (int i = 0; i < 10 && !zeroFlag; i++) step();
    armWrite = 1'b1;
    step();
    armWrite = 1'b0;
    check(gldPulse, "R9 same-cycle arm fires", int'(gldPulse), 1);
    step();
    check(!gldPulse, "R10 strobe one cycle", int'(gldPulse), 0);
    begin
      bit anyPulse = 0;
      for (int i = 0; i < 12; i++) begin step(); anyPulse |= gldPulse; end
      check(!anyPulse, "R8 no strobe without re-arming", int'(anyPulse), 0);
    end

    // R7: period mode fires right after the period flag, not the zero flag
    loadMode = 2'd1;
    for (int i = 0; i < 10 && cntOut != 1; i++) step();
    armWrite = 1'b1; step(); armWrite = 1'b0;
    begin
      bit prevP = periodFlag;
      bit good = 1;
      int seen = 0;
      for (int i = 0; i < 12; i++) begin
        step();
        if (gldPulse) begin seen++; if (!prevP) good = 0; end
        prevP = periodFlag;
      end
      check(good && seen == 1, "R7 period mode select", seen, 1);
    end

    // sweep over modes, periods and phase choices
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 7; p++) begin
        for (int ph = 0; ph < 3; ph++) begin
          loadMode = 2'(m);
          periodVal = 8'(p);
          phaseVal = (ph == 0) ? 8'd0 : (ph == 1) ? 8'(p) : 8'(p / 2);
          doReset();
          for (int i = 0; i < 50; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            syncIn   = lfsr[0] & lfsr[3];
            phaseEn  = lfsr[5] | lfsr[6];
            armWrite = lfsr[2] & lfsr[7];
            step();
          end
          syncIn = 1'b0; armWrite = 1'b0;
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule